// File: doc/BRIEF.md
# Broadcast Command Sequencer for an Elliptic-Curve Factoring Unit

This block is the local controller of one compute unit in an array of identical units that run the elliptic curve factoring method side by side. A single central controller drives the same 16-bit command word into every unit at once. Each unit decodes the word into an operation (add, subtract, multiply or square), two source register indices and one destination register index. It then gathers the source operands one word at a time from its own multi-word register file, runs the operation in the arithmetic unit, writes the result back one word at a time, and raises a ready flag. The arithmetic unit is a stand-in with fixed, data-independent latency, so every unit in the array finishes in the same cycle and the central controller can issue the next command to all of them without polling each one.

Register indices in a command are relative to the unit, so one command reaches the same register in every unit. Before a run, the host loads the modulus, the curve constant and the start point into one chosen unit; after the run it reads back the accumulated product from one chosen unit. For this it presents a unit number together with the register index and word index. The unit acts on the access only when that number matches its own strapped identifier, and only for the registers that hold preloaded inputs or the final product.

The sequencer is a four-state machine. ST_IDLE moves to ST_LOAD on an accepted start (transition "launch"). ST_LOAD steps through the operand words and moves to ST_EXEC after the last one (transition "operands gathered"). ST_EXEC waits for the arithmetic unit and moves to ST_STORE on its completion pulse (transition "result ready"). ST_STORE writes the result words and returns to ST_IDLE after the last one (transition "retire").

Top module: `ecu_cmd_seq`

## Requirements
- R1: The command word is decoded as follows: bit 0 start, bits 2:1 operation, bits 6:3 source A index, bits 10:7 source B index, bits 15:11 destination index. Register indices count from 0, and there are 21 registers (0 to 20).
- R2: Operation code 0 gives A+B, code 1 gives A-B, code 2 gives A*B and code 3 gives A*A. All results are reduced modulo 2^(E*W). Code 3 ignores source B.
- R3: A command is accepted only on a 0-to-1 change of the start bit while ready is high. Holding start high does not launch a second command. A rising start seen while busy is dropped and does not launch once the unit is idle again.
- R4: Ready falls in the cycle after an accepted start and stays low for exactly 2E+L cycles, whatever the data. L is 3(E+1)+2 for add, 2(E+1)+2 for subtract and MUL_LAT for multiply and square. E = ceil((OPERAND_BITS+1)/W) is the number of W-bit words per register.
- R5: Only the destination register changes. A destination equal to a source is allowed and uses the value the source held before the command.
- R6: A destination index of 21 or above discards the result, leaves every register unchanged and keeps the same ready timing.
- R7: A host write takes effect only when host_unit equals unit_id, ready is high and the register index is below 4 (the preload registers). host_word selects the word, and word 0 is the least significant. Any other write attempt has no effect.
- R8: host_rdata shows the addressed word when host_unit matches, ready is high and the index is below 4 or equals 20 (the product register). In every other case it reads 0.
- R9: After reset, ready is high and every register reads 0.
- R10: Changes on the command lines while busy, with no new rising start, do not alter the running operation or its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_id | input | UID_W | Strapped identifier of this unit |
| cmd | input | 16 | Broadcast command word |
| ready | output | 1 | High when the unit is idle and can take a command |
| host_en | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_unit | input | UID_W | Unit number the host access targets |
| host_reg | input | 5 | Register index of the host access |
| host_word | input | WSEL_W | Word index within the register |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Host read data, combinational |

## Verification
The assertions check, on every cycle, the launch rule (an accepted start drops ready in the next cycle and nothing else does), the busy length for each captured operation code, the absence of any host write while busy, and a zero read path while busy. Only the bench scenarios can show the computed values landing in the right register, the untouched neighbours, the discarded out-of-range destination, the unit-select filter and a full point-doubling chain. The bench gets these through the host port, sweeping all four operations over a set of operand pairs that includes zero, all ones and sign-bit patterns.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_SQR = 2'd3
    } ecu_op_e;

    // Packed MSB first: dst [15:11], src_b [10:7], src_a [6:3], op [2:1], start [0]
    typedef struct packed {
        logic [4:0] dst;
        logic [3:0] src_b;
        logic [3:0] src_a;
        ecu_op_e    op;
        logic       start;
    } ecu_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_EXEC,
        ST_STORE
    } ecu_state_e;

    localparam int CMD_W = 16;
    localparam int REG_IDX_W = 5;

endpackage

// File: rtl/ecu_regfile.sv
module ecu_regfile #(
    parameter int NUM_REGS = 21,
    parameter int NWORDS   = 2,
    parameter int WORD_W   = 8,
    parameter int IDX_W    = 5,
    parameter int WSEL_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_reg,
    input  logic [WSEL_W-1:0] rd_a_word,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_reg,
    input  logic [WSEL_W-1:0] rd_b_word,
    output logic [WORD_W-1:0] rd_b_data,
    input  logic [IDX_W-1:0]  rd_c_reg,
    input  logic [WSEL_W-1:0] rd_c_word,
    output logic [WORD_W-1:0] rd_c_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_reg,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data
);

    localparam logic [IDX_W-1:0]  LIM_REG  = IDX_W'(NUM_REGS);
    localparam logic [WSEL_W:0]   LIM_WORD = (WSEL_W+1)'(NWORDS);

    logic [WORD_W-1:0] mem_q [NUM_REGS][NWORDS];

    function automatic logic [WORD_W-1:0] fetch(input logic [IDX_W-1:0] r,
                                                input logic [WSEL_W-1:0] w);
        logic [WORD_W-1:0] v;
        v = '0;
        if (r < LIM_REG && {1'b0, w} < LIM_WORD) begin
            v = mem_q[r][w];
        end
        return v;
    endfunction

    always_comb begin
        rd_a_data = fetch(rd_a_reg, rd_a_word);
        rd_b_data = fetch(rd_b_reg, rd_b_word);
        rd_c_data = fetch(rd_c_reg, rd_c_word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                for (int w = 0; w < NWORDS; w++) begin
                    mem_q[r][w] <= '0;
                end
            end
        end else if (wr_en && wr_reg < LIM_REG && {1'b0, wr_word} < LIM_WORD) begin
            mem_q[wr_reg][wr_word] <= wr_data;
        end
    end

endmodule

// File: rtl/ecu_arith_stub.sv
module ecu_arith_stub
    import ecu_pkg::*;
#(
    parameter int NWORDS  = 2,
    parameter int WORD_W  = 8,
    parameter int WSEL_W  = 1,
    parameter int MUL_LAT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [WSEL_W-1:0] ld_word,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  ecu_op_e           op,
    input  logic              kick,
    output logic              done,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] res_word
);

    localparam int OPW     = NWORDS * WORD_W;
    localparam int LAT_ADD = 3 * (NWORDS + 1) + 2;
    localparam int LAT_SUB = 2 * (NWORDS + 1) + 2;
    localparam int LAT_M1  = (LAT_ADD > LAT_SUB) ? LAT_ADD : LAT_SUB;
    localparam int LAT_MAX = (LAT_M1 > MUL_LAT) ? LAT_M1 : MUL_LAT;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    logic [OPW-1:0]    opa_q, opb_q, res_q, res_c;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    logic [WORD_W-1:0] res_words [NWORDS];

    function automatic logic [CNT_W-1:0] lat_of(input ecu_op_e o);
        logic [CNT_W-1:0] l;
        unique case (o)
            OP_ADD:  l = CNT_W'(LAT_ADD - 1);
            OP_SUB:  l = CNT_W'(LAT_SUB - 1);
            default: l = CNT_W'(MUL_LAT - 1);
        endcase
        return l;
    endfunction

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                opa_q[k*WORD_W +: WORD_W] <= '0;
                opb_q[k*WORD_W +: WORD_W] <= '0;
            end else if (ld_en && ld_word == WSEL_W'(k)) begin
                opa_q[k*WORD_W +: WORD_W] <= a_word;
                opb_q[k*WORD_W +: WORD_W] <= b_word;
            end
        end
        assign res_words[k] = res_q[k*WORD_W +: WORD_W];
    end

    always_comb begin
        unique case (op)
            OP_ADD: res_c = opa_q + opb_q;
            OP_SUB: res_c = opa_q - opb_q;
            OP_MUL: res_c = opa_q * opb_q;
            OP_SQR: res_c = opa_q * opa_q;
        endcase
    end

    assign done     = run_q && (cnt_q == '0);
    assign res_word = res_words[rd_word];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            res_q <= '0;
        end else if (kick) begin
            run_q <= 1'b1;
            cnt_q <= lat_of(op);
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
                res_q <= res_c;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecu_seq.sv
module ecu_seq
    import ecu_pkg::*;
#(
    parameter int NWORDS   = 2,
    parameter int NUM_REGS = 21,
    parameter int WSEL_W   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CMD_W-1:0]     cmd,
    output logic                 ready,
    output logic [REG_IDX_W-1:0] src_a,
    output logic [REG_IDX_W-1:0] src_b,
    output logic [WSEL_W-1:0]    word,
    output logic                 ld_en,
    output logic                 kick,
    input  logic                 done,
    output ecu_op_e              op,
    output logic                 wr_en,
    output logic [REG_IDX_W-1:0] wr_reg
);

    localparam logic [WSEL_W-1:0]    LAST_WORD = WSEL_W'(NWORDS - 1);
    localparam logic [REG_IDX_W-1:0] REG_LIM   = REG_IDX_W'(NUM_REGS);

    ecu_cmd_t          cmd_s, cur_q;
    ecu_state_e        state_q, state_d;
    logic [WSEL_W-1:0] word_q, word_d;
    logic              start_q;
    logic              accept;

    assign cmd_s  = ecu_cmd_t'(cmd);
    assign accept = cmd_s.start && !start_q;

    // next state
    always_comb begin
        state_d = state_q;
        word_d  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (word_q == LAST_WORD) state_d = ST_EXEC;
                else word_d = word_q + 1'b1;
            end
            ST_EXEC: begin
                if (done) state_d = ST_STORE;
            end
            ST_STORE: begin
                if (word_q == LAST_WORD) state_d = ST_IDLE;
                else word_d = word_q + 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            cur_q   <= '0;
            start_q <= 1'b1;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            start_q <= cmd_s.start;
            if (state_q == ST_IDLE && accept) begin
                cur_q <= cmd_s;
            end
        end
    end

    // outputs
    always_comb begin
        ready  = 1'b0;
        ld_en  = 1'b0;
        kick   = 1'b0;
        wr_en  = 1'b0;
        src_a  = {1'b0, cur_q.src_a};
        src_b  = {1'b0, cur_q.src_b};
        word   = word_q;
        op     = cur_q.op;
        wr_reg = cur_q.dst;
        unique case (state_q)
            ST_IDLE:  ready = 1'b1;
            ST_LOAD: begin
                ld_en = 1'b1;
                kick  = (word_q == LAST_WORD);
            end
            ST_EXEC:  ;
            ST_STORE: wr_en = (cur_q.dst < REG_LIM);
        endcase
    end

endmodule

// File: rtl/ecu_cmd_seq.sv
module ecu_cmd_seq
    import ecu_pkg::*;
#(
    parameter int WORD_W       = 8,
    parameter int OPERAND_BITS = 15,
    parameter int NUM_REGS     = 21,
    parameter int HOST_IN_REGS = 4,
    parameter int PROD_REG     = 20,
    parameter int MUL_LAT      = 12,
    parameter int UID_W        = 4,
    localparam int NWORDS      = (OPERAND_BITS + 1 + WORD_W - 1) / WORD_W,
    localparam int WSEL_W      = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [UID_W-1:0]     unit_id,
    input  logic [CMD_W-1:0]     cmd,
    output logic                 ready,
    input  logic                 host_en,
    input  logic                 host_wr,
    input  logic [UID_W-1:0]     host_unit,
    input  logic [REG_IDX_W-1:0] host_reg,
    input  logic [WSEL_W-1:0]    host_word,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic [WORD_W-1:0]    host_rdata
);

    localparam logic [REG_IDX_W-1:0] IN_LIM = REG_IDX_W'(HOST_IN_REGS);
    localparam logic [REG_IDX_W-1:0] P_IDX  = REG_IDX_W'(PROD_REG);

    logic [REG_IDX_W-1:0] src_a, src_b, seq_reg, wr_reg;
    logic [WSEL_W-1:0]    seq_word, wr_word;
    logic [WORD_W-1:0]    a_word, b_word, c_word, res_word, wr_data;
    logic                 ld_en, kick, done, seq_we, wr_en;
    logic                 host_hit, host_we_ok, host_rd_ok;
    ecu_op_e              op;

    ecu_seq #(
        .NWORDS   (NWORDS),
        .NUM_REGS (NUM_REGS),
        .WSEL_W   (WSEL_W)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .ready  (ready),
        .src_a  (src_a),
        .src_b  (src_b),
        .word   (seq_word),
        .ld_en  (ld_en),
        .kick   (kick),
        .done   (done),
        .op     (op),
        .wr_en  (seq_we),
        .wr_reg (seq_reg)
    );

    ecu_arith_stub #(
        .NWORDS  (NWORDS),
        .WORD_W  (WORD_W),
        .WSEL_W  (WSEL_W),
        .MUL_LAT (MUL_LAT)
    ) alu_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_word  (seq_word),
        .a_word   (a_word),
        .b_word   (b_word),
        .op       (op),
        .kick     (kick),
        .done     (done),
        .rd_word  (seq_word),
        .res_word (res_word)
    );

    // host access gating: unit match, idle, accessible register
    always_comb begin
        host_hit   = host_en && (host_unit == unit_id) && ready;
        host_we_ok = host_hit && host_wr && (host_reg < IN_LIM);
        host_rd_ok = host_hit && !host_wr &&
                     ((host_reg < IN_LIM) || (host_reg == P_IDX));
        wr_en      = seq_we || host_we_ok;
        wr_reg     = seq_we ? seq_reg  : host_reg;
        wr_word    = seq_we ? seq_word : host_word;
        wr_data    = seq_we ? res_word : host_wdata;
        host_rdata = host_rd_ok ? c_word : '0;
    end

    ecu_regfile #(
        .NUM_REGS (NUM_REGS),
        .NWORDS   (NWORDS),
        .WORD_W   (WORD_W),
        .IDX_W    (REG_IDX_W),
        .WSEL_W   (WSEL_W)
    ) rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_reg  (src_a),
        .rd_a_word (seq_word),
        .rd_a_data (a_word),
        .rd_b_reg  (src_b),
        .rd_b_word (seq_word),
        .rd_b_data (b_word),
        .rd_c_reg  (host_reg),
        .rd_c_word (host_word),
        .rd_c_data (c_word),
        .wr_en     (wr_en),
        .wr_reg    (wr_reg),
        .wr_word   (wr_word),
        .wr_data   (wr_data)
    );

endmodule

// File: rtl/ecu_cmd_seq_chk.sv
module ecu_cmd_seq_chk #(
    parameter int NWORDS  = 2,
    parameter int WORD_W  = 8,
    parameter int MUL_LAT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cmd,
    input logic              ready,
    input logic [WORD_W-1:0] host_rdata,
    input logic              seq_we,
    input logic              host_we
);

    localparam int LAT_ADD = 2 * NWORDS + 3 * (NWORDS + 1) + 2;
    localparam int LAT_SUB = 2 * NWORDS + 2 * (NWORDS + 1) + 2;
    localparam int LAT_MUL = 2 * NWORDS + MUL_LAT;

    logic        start_d;
    logic        launch;
    logic [15:0] busy_cnt;
    logic [15:0] exp_lat;

    assign launch = ready && cmd[0] && !start_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_d  <= 1'b1;
            busy_cnt <= '0;
            exp_lat  <= '0;
        end else begin
            start_d  <= cmd[0];
            busy_cnt <= ready ? 16'd0 : busy_cnt + 16'd1;
            if (launch) begin
                unique case (cmd[2:1])
                    2'd0:    exp_lat <= 16'(LAT_ADD);
                    2'd1:    exp_lat <= 16'(LAT_SUB);
                    default: exp_lat <= 16'(LAT_MUL);
                endcase
            end
        end
    end

    a_r3_launch_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !ready);

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !launch) |=> ready);

    a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (busy_cnt == exp_lat));

    a_r7_no_host_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!host_we && $onehot0({seq_we, host_we})));

    a_r8_rdata_zero_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (host_rdata == '0));

endmodule

bind ecu_cmd_seq ecu_cmd_seq_chk #(
    .NWORDS  (NWORDS),
    .WORD_W  (WORD_W),
    .MUL_LAT (MUL_LAT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .ready      (ready),
    .host_rdata (host_rdata),
    .seq_we     (seq_we),
    .host_we    (host_we_ok)
);

// File: tb/ecu_cmd_seq_tb.sv
module ecu_cmd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int EW = 2;             // words per register for 15-bit operands, 8-bit words
    localparam int MULL = 12;
    localparam logic [3:0] MY_UNIT = 4'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmd = '0;
    logic        ready;
    logic        host_en = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_unit = '0;
    logic [4:0]  host_reg = '0;
    logic [0:0]  host_word = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecu_cmd_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .unit_id    (MY_UNIT),
        .cmd        (cmd),
        .ready      (ready),
        .host_en    (host_en),
        .host_wr    (host_wr),
        .host_unit  (host_unit),
        .host_reg   (host_reg),
        .host_word  (host_word),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    function automatic logic [15:0] mk(int op, int a, int b, int d);
        return {5'(d), 4'(b), 4'(a), 2'(op), 1'b1};
    endfunction

    function automatic logic [15:0] model(int op, logic [15:0] a, logic [15:0] b);
        logic [15:0] r;
        case (op)
            0:       r = a + b;
            1:       r = a - b;
            2:       r = a * b;
            default: r = a * a;
        endcase
        return r;
    endfunction

    function automatic int exp_lat(int op);
        if (op == 0) return 2*EW + 3*(EW+1) + 2;
        if (op == 1) return 2*EW + 2*(EW+1) + 2;
        return 2*EW + MULL;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input int r, input logic [15:0] v, input logic [3:0] u);
        @(negedge clk);
        host_en = 1'b1; host_wr = 1'b1; host_unit = u; host_reg = 5'(r);
        host_word = 1'b0; host_wdata = v[7:0];
        @(negedge clk);
        host_word = 1'b1; host_wdata = v[15:8];
        @(negedge clk);
        host_en = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hread(input int r, input logic [3:0] u, output logic [15:0] v);
        @(negedge clk);
        host_en = 1'b1; host_wr = 1'b0; host_unit = u; host_reg = 5'(r);
        host_word = 1'b0;
        #1 v[7:0] = host_rdata;
        host_word = 1'b1;
        #1 v[15:8] = host_rdata;
        host_en = 1'b0;
    endtask

    task automatic launch(input int op, input int a, input int b, input int d);
        @(negedge clk);
        cmd = mk(op, a, b, d);
    endtask

    task automatic wait_done(input int already, output int lat);
        lat = already;
        for (int g = 0; g < 400; g++) begin
            @(negedge clk);
            if (ready) break;
            lat++;
        end
        cmd = '0;
        @(negedge clk);
    endtask

    task automatic run(input int op, input int a, input int b, input int d, output int lat);
        launch(op, a, b, d);
        wait_done(0, lat);
    endtask

    function automatic logic [31:0] pat(int i);
        case (i)
            0:       return {16'h0000, 16'h0000};
            1:       return {16'hFFFF, 16'h0001};
            2:       return {16'h1234, 16'h5678};
            3:       return {16'h8000, 16'h8000};
            4:       return {16'h00FF, 16'hFF01};
            default: return {16'hABCD, 16'h0003};
        endcase
    endfunction

    function automatic logic [15:0] dbl_step(int k);
        // {op[3:0], srcA[3:0], srcB[3:0], dst[3:0]} ; dst 15 stands for product register 20
        case (k)
            0:       return 16'h0_2_3_4;
            1:       return 16'h1_2_3_5;
            2:       return 16'h3_4_0_6;
            3:       return 16'h3_5_0_7;
            4:       return 16'h1_6_7_8;
            5:       return 16'h2_6_7_9;
            6:       return 16'h2_8_1_A;
            7:       return 16'h0_7_A_B;
            default: return 16'h2_8_B_F;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] v, a, b, last;
        int lat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk(ready === 1'b1, "R9 ready after reset", 32'(ready), 1);
        for (int r = 0; r < 4; r++) begin
            hread(r, MY_UNIT, v);
            chk(v === 16'h0, "R9 preload register cleared", v, 0);
        end
        hread(20, MY_UNIT, v);
        chk(v === 16'h0, "R9 product register cleared", v, 0);

        // R1 R2 R4 R5: sweep of every operation over operand patterns
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 6; i++) begin
                a = pat(i)[31:16];
                b = pat(i)[15:0];
                hwrite(0, a, MY_UNIT);
                hwrite(1, b, MY_UNIT);
                run(op, 0, 1, 20, lat);
                chk(lat == exp_lat(op), "R4 busy length", lat, exp_lat(op));
                hread(20, MY_UNIT, v);
                chk(v === model(op, a, b), "R2 R1 result in product register", v, model(op, a, b));
                hread(0, MY_UNIT, v);
                chk(v === a, "R5 source A untouched", v, a);
                hread(1, MY_UNIT, v);
                chk(v === b, "R5 source B untouched", v, b);
            end
        end

        // R2 square ignores source B: pick different B index
        hwrite(0, 16'h0123, MY_UNIT);
        hwrite(1, 16'h7777, MY_UNIT);
        run(3, 0, 1, 20, lat);
        hread(20, MY_UNIT, v);
        chk(v === model(3, 16'h0123, 16'h0), "R2 square ignores source B", v, model(3, 16'h0123, 16'h0));

        // R5 destination equal to a source
        hwrite(2, 16'h1111, MY_UNIT);
        hwrite(3, 16'h0222, MY_UNIT);
        run(0, 2, 3, 2, lat);
        hread(2, MY_UNIT, v);
        chk(v === 16'h1333, "R5 dst equals source", v, 16'h1333);
        hread(3, MY_UNIT, v);
        chk(v === 16'h0222, "R5 other source untouched", v, 16'h0222);

        // R6 out-of-range destination
        hread(20, MY_UNIT, last);
        run(2, 0, 1, 25, lat);
        chk(lat == exp_lat(2), "R6 timing unchanged", lat, exp_lat(2));
        hread(20, MY_UNIT, v);
        chk(v === last, "R6 product register unchanged", v, last);
        hread(0, MY_UNIT, v);
        chk(v === 16'h0123, "R6 register 0 unchanged", v, 16'h0123);
        hread(1, MY_UNIT, v);
        chk(v === 16'h7777, "R6 register 1 unchanged", v, 16'h7777);

        // R7 R8 unit select and protected registers
        hwrite(0, 16'hBEEF, 4'd6);
        hread(0, MY_UNIT, v);
        chk(v === 16'h0123, "R7 foreign unit write ignored", v, 16'h0123);
        hread(0, 4'd6, v);
        chk(v === 16'h0, "R8 foreign unit read is zero", v, 0);
        hwrite(5, 16'h7777, MY_UNIT);
        hread(5, MY_UNIT, v);
        chk(v === 16'h0, "R8 temporary not readable", v, 0);
        hwrite(0, 16'h0001, MY_UNIT);
        run(0, 5, 0, 20, lat);
        hread(20, MY_UNIT, v);
        chk(v === 16'h0001, "R7 temporary write ignored", v, 16'h0001);

        // R7 R8 host access while busy
        hwrite(1, 16'h4444, MY_UNIT);
        launch(2, 0, 1, 20);
        hwrite(1, 16'h9999, MY_UNIT);
        hread(0, MY_UNIT, v);
        chk(v === 16'h0, "R8 read while busy is zero", v, 0);
        wait_done(4, lat);
        chk(lat == exp_lat(2), "R4 busy length with host traffic", lat, exp_lat(2));
        hread(1, MY_UNIT, v);
        chk(v === 16'h4444, "R7 write while busy ignored", v, 16'h4444);
        hread(20, MY_UNIT, v);
        chk(v === 16'h4444, "R2 multiply under host traffic", v, 16'h4444);

        // R3 start edge while busy dropped, held start no relaunch
        hwrite(0, 16'h1000, MY_UNIT);
        hwrite(1, 16'h0234, MY_UNIT);
        launch(0, 0, 1, 20);
        repeat (3) @(negedge clk);
        cmd = '0;
        @(negedge clk);
        cmd = mk(1, 0, 1, 20);
        lat = 4;
        for (int g = 0; g < 400; g++) begin
            @(negedge clk);
            if (ready) break;
            lat++;
        end
        chk(lat == exp_lat(0), "R3 busy start edge has no effect on timing", lat, exp_lat(0));
        for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            chk(ready === 1'b1, "R3 held start does not relaunch", 32'(ready), 1);
        end
        cmd = '0;
        @(negedge clk);
        hread(20, MY_UNIT, v);
        chk(v === 16'h1234, "R3 dropped command left result", v, 16'h1234);

        // R10 command lines change while busy
        hwrite(3, 16'h0555, MY_UNIT);
        launch(0, 0, 1, 20);
        repeat (2) @(negedge clk);
        cmd = mk(2, 3, 3, 3);
        wait_done(2, lat);
        chk(lat == exp_lat(0), "R10 timing follows captured op", lat, exp_lat(0));
        hread(20, MY_UNIT, v);
        chk(v === 16'h1234, "R10 captured command result", v, 16'h1234);
        hread(3, MY_UNIT, v);
        chk(v === 16'h0555, "R10 changed destination untouched", v, 16'h0555);

        // R2 R4 R5 point doubling chain
        for (int p = 0; p < 3; p++) begin
            logic [15:0] x, z, k, t1, t2, t3, t4, t5, t6, t7, x2, z2;
            case (p)
                0:       begin x = 16'h0003; z = 16'h0001; k = 16'h0002; end
                1:       begin x = 16'h1234; z = 16'h00F1; k = 16'h0B0E; end
                default: begin x = 16'hFFFE; z = 16'h7FFF; k = 16'h0101; end
            endcase
            t1 = x + z; t2 = x - z; t3 = t1 * t1; t4 = t2 * t2;
            t5 = t3 - t4; x2 = t3 * t4; t6 = t5 * k; t7 = t4 + t6; z2 = t5 * t7;
            hwrite(1, k, MY_UNIT);
            hwrite(2, x, MY_UNIT);
            hwrite(3, z, MY_UNIT);
            for (int s = 0; s < 9; s++) begin
                logic [15:0] st;
                int d;
                st = dbl_step(s);
                d = (st[3:0] == 4'hF) ? 20 : int'(st[3:0]);
                run(int'(st[15:12]), int'(st[11:8]), int'(st[7:4]), d, lat);
                chk(lat == exp_lat(int'(st[15:12])), "R4 doubling step latency", lat, exp_lat(int'(st[15:12])));
            end
            hread(20, MY_UNIT, v);
            chk(v === z2, "R2 doubling z result", v, z2);
            run(0, 9, 12, 20, lat);
            hread(20, MY_UNIT, v);
            chk(v === x2, "R5 doubling x result", v, x2);
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule